// File: doc/BRIEF.md
# Core Power-Domain Sequencing Controller

This controller steps one processor core power domain, and an optional SIMD/floating-point companion domain, through power-down and power-up in a fixed order. It drives clamps, power switches and reset. The core must first finish its own software preparation, which ends with the core idling in wait-for-interrupt. The controller takes the core's standby indication as the sign that this preparation is complete. Only after that does it clamp the domain outputs and then cut power.

On power-up the core power-on reset goes active before any switch is turned on. Once every enabled switch reports power-good, the reset is held for a fixed number of cycles. The clamps are then released, and the reset is released last. A power-up request can bring up both domains, or the core domain alone with the companion left unpowered and clamped. Each switch handshake has a cycle timeout. When it expires, the controller enters a sticky fault state with all outputs in their safe state. Only system reset leaves the fault state.

All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After system reset the block reports status ON (3), both isolation enables high, both power enables high, the core power-on reset high (released) and the fault flag low.
- R2: A power-down request taken in ON moves the status to POWERING_DOWN (1). Both isolation enables stay high until the standby input has been sampled high. Both go low in the cycle after that sample.
- R3: A power enable falls only while both isolation enables are already low. Power enables drop one cycle after the clamps engage.
- R4: Power-down finishes when both power-good inputs are sampled low. The status is then OFF (0), with clamps low, power enables low and the reset released.
- R5: A power-up request taken in OFF drives the reset low and the status to POWERING_UP (2) for one cycle before any power enable rises.
- R6: Once every enabled domain reports power-good, the reset stays low for HOLD_CYC more cycles. The clamps of the powered domains then rise, and the reset rises one cycle after them, with status ON.
- R7: When the core-only input is high with the power-up request, the companion power enable and isolation enable stay low through power-up and in ON. The companion power-good input is ignored. The following power-down still completes.
- R8: If a switch handshake is not met within TIMEOUT_CYC cycles, the fault flag goes high and the status reads OFF (0). Clamps, power enables and reset are all driven low, and this persists until system reset.
- R9: A power-up request in ON, a power-down request in OFF, and any request during a sequence or in the fault state have no effect.
- R10: The status encoding is OFF = 0, POWERING_DOWN = 1, POWERING_UP = 2, ON = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dn_req | input | 1 | Power-down request, sampled in ON |
| up_req | input | 1 | Power-up request, sampled in OFF |
| up_core_only | input | 1 | With up_req: leave the companion domain unpowered |
| core_standby | input | 1 | Core is idle in wait-for-interrupt |
| core_pwr_ok | input | 1 | Core domain power-good acknowledge |
| simd_pwr_ok | input | 1 | Companion domain power-good acknowledge |
| core_iso_n | output | 1 | Core output clamp, low = clamped |
| simd_iso_n | output | 1 | Companion output clamp, low = clamped |
| core_pwr_en | output | 1 | Core domain power-switch enable |
| simd_pwr_en | output | 1 | Companion domain power-switch enable |
| core_por_n | output | 1 | Core power-on reset, low = in reset |
| status | output | 2 | Sequencing status, encoded as in R10 |
| err | output | 1 | Sticky handshake-timeout fault flag |

## Verification
The bench builds the block with TIMEOUT_CYC = 8 and the default HOLD_CYC = 16. The short timeout lets a stuck power-good input (one never rising on power-up, one never falling on power-down) reach the fault state within a few cycles. The full 16-cycle reset hold is then measured exactly. A behavioural switch model with a settable latency and stuck-high or stuck-low options answers each enable. This covers both full and core-only power-up, and requests that arrive mid-sequence.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [3:0] {
    ST_ON, ST_WAIT_IDLE, ST_CLAMP, ST_CUT, ST_OFF,
    ST_RESET, ST_RAMP, ST_HOLD, ST_UNCLAMP, ST_FAULT
  } seq_state_t;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_DOWN = 2'd1,
    PS_UP   = 2'd2,
    PS_ON   = 2'd3
  } pwr_status_t;
endpackage

// File: rtl/pwrseq_cnt.sv
// Cycle counter: runs while 'run' is high, clears otherwise; 'last' marks LIMIT-th cycle.
module pwrseq_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run)              cnt_q <= '0;
    else if (!last)             cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/pwrseq_out.sv
// Output decode from sequencer state.
module pwrseq_out
  import pwrseq_pkg::*;
(
  input  seq_state_t state,
  input  logic       simd_on,
  output logic       core_iso_n,
  output logic       simd_iso_n,
  output logic       core_pwr_en,
  output logic       simd_pwr_en,
  output logic       core_por_n,
  output logic [1:0] status,
  output logic       err
);
  logic clamps_open, powered, released;

  always_comb begin
    clamps_open = 1'b0;
    powered     = 1'b0;
    released    = 1'b0;
    status      = PS_OFF;
    unique case (state)
      ST_ON, ST_WAIT_IDLE: begin
        clamps_open = 1'b1; powered = 1'b1; released = 1'b1;
        status = (state == ST_ON) ? PS_ON : PS_DOWN;
      end
      ST_CLAMP:   begin powered = 1'b1; released = 1'b1; status = PS_DOWN; end
      ST_CUT:     begin released = 1'b1; status = PS_DOWN; end
      ST_OFF:     begin released = 1'b1; status = PS_OFF; end
      ST_RESET:   status = PS_UP;
      ST_RAMP,
      ST_HOLD:    begin powered = 1'b1; status = PS_UP; end
      ST_UNCLAMP: begin clamps_open = 1'b1; powered = 1'b1; status = PS_UP; end
      default:    status = PS_OFF;
    endcase
  end

  assign core_iso_n  = clamps_open;
  assign simd_iso_n  = clamps_open & simd_on;
  assign core_pwr_en = powered;
  assign simd_pwr_en = powered & simd_on;
  assign core_por_n  = released;
  assign err         = (state == ST_FAULT);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned HOLD_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dn_req,
  input  logic       up_req,
  input  logic       up_core_only,
  input  logic       core_standby,
  input  logic       core_pwr_ok,
  input  logic       simd_pwr_ok,
  output logic       core_iso_n,
  output logic       simd_iso_n,
  output logic       core_pwr_en,
  output logic       simd_pwr_en,
  output logic       core_por_n,
  output logic [1:0] status,
  output logic       err
);
  seq_state_t state_q, state_d;
  logic       simd_on_q;
  logic       wait_run, hold_run, wait_last, hold_last;
  logic       down_ack, up_ack;

  assign wait_run = (state_q == ST_CUT) || (state_q == ST_RAMP);
  assign hold_run = (state_q == ST_HOLD);
  assign down_ack = !core_pwr_ok && !simd_pwr_ok;
  assign up_ack   = core_pwr_ok && (simd_pwr_ok || !simd_on_q);

  pwrseq_cnt #(.LIMIT(TIMEOUT_CYC)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .last(wait_last)
  );

  pwrseq_cnt #(.LIMIT(HOLD_CYC)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .run(hold_run), .last(hold_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:        if (dn_req)       state_d = ST_WAIT_IDLE;
      ST_WAIT_IDLE: if (core_standby) state_d = ST_CLAMP;
      ST_CLAMP:                       state_d = ST_CUT;
      ST_CUT: begin
        if (down_ack)       state_d = ST_OFF;
        else if (wait_last) state_d = ST_FAULT;
      end
      ST_OFF:       if (up_req)       state_d = ST_RESET;
      ST_RESET:                       state_d = ST_RAMP;
      ST_RAMP: begin
        if (up_ack)         state_d = ST_HOLD;
        else if (wait_last) state_d = ST_FAULT;
      end
      ST_HOLD:      if (hold_last)    state_d = ST_UNCLAMP;
      ST_UNCLAMP:                     state_d = ST_ON;
      default:                        state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ON;
      simd_on_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_OFF && up_req) simd_on_q <= !up_core_only;
    end
  end

  pwrseq_out u_out (
    .state(state_q), .simd_on(simd_on_q),
    .core_iso_n(core_iso_n), .simd_iso_n(simd_iso_n),
    .core_pwr_en(core_pwr_en), .simd_pwr_en(simd_pwr_en),
    .core_por_n(core_por_n), .status(status), .err(err)
  );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_standby,
  input logic       core_iso_n,
  input logic       simd_iso_n,
  input logic       core_pwr_en,
  input logic       simd_pwr_en,
  input logic       core_por_n,
  input logic [1:0] status,
  input logic       err
);
  a_r2_idle_before_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_iso_n) |-> $past(core_standby));

  a_r3_core_cut_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> (!core_iso_n && !simd_iso_n));

  a_r3_simd_cut_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(simd_pwr_en) |-> (!core_iso_n && !simd_iso_n));

  a_r5_reset_before_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_en) |-> (!core_por_n && $past(!core_por_n)));

  a_r6_unclamp_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_por_n) |-> (core_iso_n && $past(core_iso_n)));

  a_r7_unpowered_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    !simd_pwr_en |-> !simd_iso_n);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && status == 2'd0));
endmodule

bind pwr_seq_ctrl pwrseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_standby(core_standby),
  .core_iso_n(core_iso_n), .simd_iso_n(simd_iso_n),
  .core_pwr_en(core_pwr_en), .simd_pwr_en(simd_pwr_en),
  .core_por_n(core_por_n), .status(status), .err(err)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  localparam int TMO  = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dn_req = 0, up_req = 0, up_core_only = 0, core_standby = 0;
  logic core_pwr_ok = 1'b1, simd_pwr_ok = 1'b1;
  logic core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n, err;
  logic [1:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .dn_req(dn_req), .up_req(up_req),
    .up_core_only(up_core_only), .core_standby(core_standby),
    .core_pwr_ok(core_pwr_ok), .simd_pwr_ok(simd_pwr_ok),
    .core_iso_n(core_iso_n), .simd_iso_n(simd_iso_n),
    .core_pwr_en(core_pwr_en), .simd_pwr_en(simd_pwr_en),
    .core_por_n(core_por_n), .status(status), .err(err)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- power switch model ----------------
  int  lat = 2;
  bit  core_stuck_hi = 0, simd_stuck_lo = 0;
  int  c_age = 100, s_age = 100;
  logic c_prev = 1'b1, s_prev = 1'b1;

  always @(posedge clk) begin
    #2;
    if (core_pwr_en != c_prev) begin c_age = 0; c_prev = core_pwr_en; end else c_age++;
    if (simd_pwr_en != s_prev) begin s_age = 0; s_prev = simd_pwr_en; end else s_age++;
    core_pwr_ok = core_stuck_hi ? 1'b1 : ((c_age >= lat) ? c_prev : !c_prev);
    simd_pwr_ok = simd_stuck_lo ? 1'b0 : ((s_age >= lat) ? s_prev : !s_prev);
  end

  // ---------------- reference model ----------------
  localparam int M_ON = 0, M_WAIT = 1, M_CLAMP = 2, M_CUT = 3, M_OFF = 4,
                 M_RST = 5, M_RAMP = 6, M_HOLD = 7, M_UNC = 8, M_ERR = 9;
  int mph = M_ON, mcnt = 0;
  bit msimd = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      mph = M_ON; mcnt = 0; msimd = 1;
    end else begin
      bit e_ciso, e_siso, e_cpwr, e_spwr, e_por, e_err;
      int e_st;
      e_ciso = (mph == M_ON) || (mph == M_WAIT) || (mph == M_UNC);
      e_siso = e_ciso && msimd;
      e_cpwr = (mph == M_ON) || (mph == M_WAIT) || (mph == M_CLAMP) ||
               (mph == M_RAMP) || (mph == M_HOLD) || (mph == M_UNC);
      e_spwr = e_cpwr && msimd;
      e_por  = (mph <= M_OFF);
      e_err  = (mph == M_ERR);
      if (mph == M_ON) e_st = 3;
      else if (mph >= M_WAIT && mph <= M_CUT) e_st = 1;
      else if (mph >= M_RST && mph <= M_UNC) e_st = 2;
      else e_st = 0;
      chk("R10 status", status == e_st, status, e_st);
      if (core_iso_n != e_ciso) chk("R2 core_iso_n", 0, core_iso_n, e_ciso);
      if (simd_iso_n != e_siso) chk("R7 simd_iso_n", 0, simd_iso_n, e_siso);
      if (core_pwr_en != e_cpwr) chk("R3 core_pwr_en", 0, core_pwr_en, e_cpwr);
      if (simd_pwr_en != e_spwr) chk("R3 simd_pwr_en", 0, simd_pwr_en, e_spwr);
      if (core_por_n != e_por) chk("R6 core_por_n", 0, core_por_n, e_por);
      if (err != e_err) chk("R8 err", 0, err, e_err);
      case (mph)
        M_ON:    if (dn_req) mph = M_WAIT;
        M_WAIT:  if (core_standby) mph = M_CLAMP;
        M_CLAMP: begin mph = M_CUT; mcnt = 0; end
        M_CUT: begin
          if (!core_pwr_ok && !simd_pwr_ok) mph = M_OFF;
          else if (mcnt == TMO - 1) mph = M_ERR;
          else mcnt++;
        end
        M_OFF:   if (up_req) begin msimd = !up_core_only; mph = M_RST; end
        M_RST:   begin mph = M_RAMP; mcnt = 0; end
        M_RAMP: begin
          if (core_pwr_ok && (simd_pwr_ok || !msimd)) begin mph = M_HOLD; mcnt = 0; end
          else if (mcnt == TMO - 1) mph = M_ERR;
          else mcnt++;
        end
        M_HOLD:  if (mcnt == HOLD - 1) mph = M_UNC; else mcnt++;
        M_UNC:   mph = M_ON;
        default: mph = M_ERR;
      endcase
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_dn();
    dn_req = 1; tick(); dn_req = 0;
  endtask

  task automatic pulse_up(input bit core_only);
    up_req = 1; up_core_only = core_only; tick(); up_req = 0; up_core_only = 0;
  endtask

  task automatic wait_status(input int v, input string req);
    int n = 0;
    @(negedge clk);
    while (status != v && n < 200) begin @(negedge clk); n++; end
    chk(req, status == v, status, v);
  endtask

  task automatic do_reset();
    rst_n = 0; tick(3); rst_n = 1; tick();
  endtask

  // ---------------- scenario ----------------
  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 status", status == 3, status, 3);
    chk("R1 outputs", {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n, err} == 6'b111110,
        {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n, err}, 6'b111110);

    // R9: up request while ON has no effect
    tick(); pulse_up(0); tick(2);
    @(negedge clk);
    chk("R9 up in ON", status == 3, status, 3);

    // R2: clamps wait for standby
    tick(); pulse_dn(); tick(5);
    @(negedge clk);
    chk("R2 waiting clamps", {core_iso_n, simd_iso_n} == 2'b11, {core_iso_n, simd_iso_n}, 3);
    chk("R2 status", status == 1, status, 1);
    tick(); core_standby = 1;
    wait_status(0, "R4 reached OFF");
    chk("R4 outputs", {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n} == 5'b00001,
        {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n}, 1);
    core_standby = 0;

    // R9: down request while OFF
    tick(); pulse_dn(); tick(2);
    @(negedge clk);
    chk("R9 dn in OFF", status == 0, status, 0);

    // Full power-up, R5/R6
    tick(); lat = 3; pulse_up(0);
    @(negedge clk);
    chk("R5 status up", status == 2, status, 2);
    chk("R5 reset first", {core_por_n, core_pwr_en, simd_pwr_en} == 3'b000,
        {core_por_n, core_pwr_en, simd_pwr_en}, 0);
    tick(); pulse_dn();   // R9: ignored mid-sequence
    @(negedge clk);
    chk("R9 dn during up", status == 2, status, 2);
    begin
      int n = 0;
      while (!(core_pwr_ok && simd_pwr_ok) && n < 100) begin @(negedge clk); n++; end
      n = 0;
      while (!core_iso_n && n < 100) begin n++; @(negedge clk); end
      chk("R6 hold length", n == HOLD + 1, n, HOLD + 1);
      chk("R6 por low at unclamp", core_por_n == 0, core_por_n, 0);
      @(negedge clk);
      chk("R6 por released", core_por_n == 1, core_por_n, 1);
      chk("R6 status ON", status == 3, status, 3);
      chk("R6 companion up", {simd_pwr_en, simd_iso_n} == 2'b11, {simd_pwr_en, simd_iso_n}, 3);
    end

    // Core-only power-up, R7
    tick(); pulse_dn(); core_standby = 1;
    wait_status(0, "R4 second down");
    core_standby = 0; lat = 2;
    tick(); pulse_up(1);
    begin
      bit leak = 0;
      int n = 0;
      @(negedge clk);
      while (status != 3 && n < 200) begin
        if (simd_pwr_en || simd_iso_n) leak = 1;
        @(negedge clk); n++;
      end
      chk("R7 companion kept off", leak == 0, leak, 0);
      chk("R7 ON companion", {simd_pwr_en, simd_iso_n, core_iso_n} == 3'b001,
          {simd_pwr_en, simd_iso_n, core_iso_n}, 1);
    end
    tick(); pulse_dn(); core_standby = 1;
    wait_status(0, "R7 core-only down");
    core_standby = 0;

    // R8: power-up timeout (companion never acknowledges)
    simd_stuck_lo = 1;
    tick(); pulse_up(0);
    tick(TMO + 4);
    @(negedge clk);
    chk("R8 fault flag", err == 1, err, 1);
    chk("R8 status OFF", status == 0, status, 0);
    chk("R8 safe outputs", {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n} == 5'b0,
        {core_iso_n, simd_iso_n, core_pwr_en, simd_pwr_en, core_por_n}, 0);
    tick(); pulse_up(0); tick(3);
    @(negedge clk);
    chk("R9 up in fault", err == 1, err, 1);
    simd_stuck_lo = 0;
    tick(); do_reset();

    // R8: power-down timeout (core switch never turns off)
    core_stuck_hi = 1;
    tick(); pulse_dn(); core_standby = 1;
    tick(TMO + 6);
    @(negedge clk);
    chk("R8 down timeout", err == 1, err, 1);
    core_standby = 0; core_stuck_hi = 0;
    tick(); do_reset();
    @(negedge clk);
    chk("R1 recovered", {status, err} == 3'b110, {status, err}, 6);

    tick(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule